// File: doc/BRIEF.md
# Halfword Instruction Fetch Stage

This block is the front stage of a four-stage in-order pipeline. It owns the program counter, reads 32-bit words from instruction memory and extracts the 16-bit instruction that the counter points at. Every clock it either steps to the next halfword or, when the last pipeline stage requests a redirect, jumps to the target that stage supplies. The fetched instruction, the counter value that fetched it and a valid flag are registered for the operand stage. The operand stage needs that counter value to form PC-relative addresses.

The memory read port is a word address taken straight from the counter register, with read data returned in the same cycle. Bit 1 of the counter selects which half of the returned word is the instruction. A stall input from the operand stage freezes the stage. A redirect always wins over a stall. A redirect also replaces the slot being fetched with a no-op and marks it invalid, so that the wrong-path instruction never executes.

Top module: `hwf_fetch_stage`

## Requirements
- R1: While `rst` is high at a clock edge, the counter becomes 0 (`mem_addr` = 0), `ir_out` becomes the no-op code 16'hF000, `ir_pc` becomes 0 and `ir_valid` becomes 0.
- R2: On an edge with `rst`, `br_take` and `stall` all low, the counter advances by 2 and wraps modulo 2^AW.
- R3: `mem_addr` always equals the counter with its two low bits dropped, which is counter bits [AW-1:2].
- R4: On a sequential fetch, `ir_out` receives `mem_rdata[15:0]` when counter bit 1 is 0 and `mem_rdata[31:16]` when it is 1.
- R5: On a sequential fetch, `ir_pc` receives the counter value that was used to address the memory for that fetch.
- R6: On an edge with `br_take` high, the counter loads `br_target` with bit 0 forced to 0.
- R7: On an edge with `br_take` high, `ir_out` becomes the no-op 16'hF000, `ir_valid` becomes 0 and `ir_pc` takes the counter value being replaced.
- R8: On an edge with `stall` high and `br_take` low, the counter, `ir_out`, `ir_pc` and `ir_valid` all keep their values.
- R9: If `br_take` and `stall` are high at the same edge, the redirect of R6 and R7 takes effect and the stall has no effect.
- R10: A sequential fetch sets `ir_valid` to 1.
- R11: A sequential fetch at counter 16'hFFFE (AW = 16) fetches from word address 16'h3FFF, high half, and the counter then becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Operand stage is blocked; hold everything |
| br_take | input | 1 | Redirect request from the last stage |
| br_target | input | AW | Redirect byte address (bit 0 ignored) |
| mem_addr | output | AW-2 | Instruction memory word address |
| mem_rdata | input | 32 | Word returned for `mem_addr` in the same cycle |
| ir_out | output | 16 | Fetched instruction register |
| ir_pc | output | AW | Counter value that fetched `ir_out` |
| ir_valid | output | 1 | `ir_out` holds a real instruction |

## Verification
The embedded properties check, on every cycle, that the counter steps by two on a free edge, that it lands on the even-aligned target after a redirect, that a redirect squashes the slot, that a stall freezes the counter and interstage registers, and that `ir_pc` tags each fetch with the counter that addressed it. Halfword selection against real memory contents, the wrap at the top of the address space, the priority of a redirect over a stall and the exact output values after reset in the middle of a run can only be shown by the bench. The bench drives those sequences and compares every output against a behavioural model on every clock.

// File: rtl/hwf_pkg.sv
package hwf_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 32;

  typedef logic [HALF_W-1:0] half_t;
  typedef logic [WORD_W-1:0] word_t;

  localparam half_t HWF_NOP = 16'hF000;
endpackage

// File: rtl/hwf_pc_next.sv
module hwf_pc_next #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] pc,
  input  logic          br_take,
  input  logic [AW-1:0] br_target,
  output logic [AW-1:0] pc_nxt
);
  localparam logic [AW-1:0] STEP      = AW'(2);
  localparam logic [AW-1:0] EVEN_MASK = ~AW'(1);

  logic [AW-1:0] seq_pc;
  logic [AW-1:0] tgt_even;

  always_comb begin
    seq_pc   = pc + STEP;
    tgt_even = br_target & EVEN_MASK;
    pc_nxt   = br_take ? tgt_even : seq_pc;
  end
endmodule

// File: rtl/hwf_half_pick.sv
module hwf_half_pick
  import hwf_pkg::*;
#(
  parameter bit HI_FIRST = 1'b0
) (
  input  word_t word_in,
  input  logic  sel,
  output half_t half_out
);
  generate
    if (HI_FIRST) begin : g_hi_first
      always_comb half_out = sel ? word_in[HALF_W-1:0] : word_in[WORD_W-1:HALF_W];
    end else begin : g_lo_first
      always_comb half_out = sel ? word_in[WORD_W-1:HALF_W] : word_in[HALF_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/hwf_stage_regs.sv
module hwf_stage_regs
  import hwf_pkg::*;
#(
  parameter int            AW       = 16,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stall,
  input  logic          br_take,
  input  logic [AW-1:0] pc_nxt,
  input  half_t         fetched,
  output logic [AW-1:0] pc_q,
  output half_t         ir_q,
  output logic [AW-1:0] ir_pc_q,
  output logic          valid_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= RESET_PC;
      ir_q    <= HWF_NOP;
      ir_pc_q <= '0;
      valid_q <= 1'b0;
    end else if (br_take) begin
      pc_q    <= pc_nxt;
      ir_q    <= HWF_NOP;
      ir_pc_q <= pc_q;
      valid_q <= 1'b0;
    end else if (!stall) begin
      pc_q    <= pc_nxt;
      ir_q    <= fetched;
      ir_pc_q <= pc_q;
      valid_q <= 1'b1;
    end
  end
endmodule

// File: rtl/hwf_fetch_stage.sv
module hwf_fetch_stage
  import hwf_pkg::*;
#(
  parameter int            AW       = 16,
  parameter bit            HI_FIRST = 1'b0,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall,
  input  logic              br_take,
  input  logic [AW-1:0]     br_target,
  output logic [AW-3:0]     mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [HALF_W-1:0] ir_out,
  output logic [AW-1:0]     ir_pc,
  output logic              ir_valid
);
  logic [AW-1:0] pc;
  logic [AW-1:0] pc_nxt;
  half_t         fetched;

  assign mem_addr = pc[AW-1:2];

  hwf_pc_next #(.AW(AW)) u_next (
    .pc        (pc),
    .br_take   (br_take),
    .br_target (br_target),
    .pc_nxt    (pc_nxt)
  );

  hwf_half_pick #(.HI_FIRST(HI_FIRST)) u_pick (
    .word_in  (mem_rdata),
    .sel      (pc[1]),
    .half_out (fetched)
  );

  hwf_stage_regs #(.AW(AW), .RESET_PC(RESET_PC)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .stall   (stall),
    .br_take (br_take),
    .pc_nxt  (pc_nxt),
    .fetched (fetched),
    .pc_q    (pc),
    .ir_q    (ir_out),
    .ir_pc_q (ir_pc),
    .valid_q (ir_valid)
  );

  // R2: a free edge steps the counter by one halfword
  assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!stall && !br_take) |=> (pc == $past(pc) + AW'(2)));

  // R6: redirect lands on the even-aligned target
  assert_branch_load_R6: assert property (@(posedge clk) disable iff (rst)
    br_take |=> (pc == {$past(br_target[AW-1:1]), 1'b0}));

  // R7: the slot fetched under a redirect is squashed
  assert_squash_R7: assert property (@(posedge clk) disable iff (rst)
    br_take |=> (!ir_valid && ir_out == HWF_NOP));

  // R8: a stall without redirect freezes the stage
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (stall && !br_take) |=> ($stable(pc) && $stable(ir_out) && $stable(ir_pc) && $stable(ir_valid)));

  // R5: the interstage PC tags the fetch with its own address
  assert_pc_tag_R5: assert property (@(posedge clk) disable iff (rst)
    (!stall && !br_take) |=> (ir_pc == $past(pc) && ir_valid));
endmodule

// File: tb/hwf_fetch_stage_tb.sv
`timescale 1ns/1ps
module hwf_fetch_stage_tb;
  localparam int AW = 16;
  localparam logic [15:0] NOP = 16'hF000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          stall = 1'b0;
  logic          br_take = 1'b0;
  logic [AW-1:0] br_target = '0;
  logic [AW-3:0] mem_addr;
  logic [31:0]   mem_rdata;
  logic [15:0]   ir_out;
  logic [AW-1:0] ir_pc;
  logic          ir_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [AW-1:0] m_pc = '0;
  logic [15:0]   m_ir = NOP;
  logic [AW-1:0] m_irpc = '0;
  logic          m_valid = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] memf(input logic [AW-3:0] a);
    logic [15:0] x;
    x = {2'b00, a};
    return {x * 16'h0029 + 16'h1111, x ^ 16'h5A5A};
  endfunction

  assign mem_rdata = memf(mem_addr);

  hwf_fetch_stage #(.AW(AW)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .stall     (stall),
    .br_take   (br_take),
    .br_target (br_target),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .ir_out    (ir_out),
    .ir_pc     (ir_pc),
    .ir_valid  (ir_valid)
  );

  task automatic chk(input string tag, input string fld, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, fld, act, exp, $time);
    end
  endtask

  task automatic step(input logic r, input logic s, input logic b, input logic [AW-1:0] t, input string tag);
    logic [31:0] w;
    rst = r; stall = s; br_take = b; br_target = t;
    @(posedge clk);
    if (r) begin
      m_pc = '0; m_ir = NOP; m_irpc = '0; m_valid = 1'b0;
    end else if (b) begin
      m_irpc = m_pc; m_pc = t & ~AW'(1); m_ir = NOP; m_valid = 1'b0;
    end else if (!s) begin
      w = memf(m_pc[AW-1:2]);
      m_ir = m_pc[1] ? w[31:16] : w[15:0];
      m_irpc = m_pc; m_pc = m_pc + AW'(2); m_valid = 1'b1;
    end
    @(negedge clk);
    chk(tag, "R3 mem_addr", 32'(mem_addr), 32'(m_pc[AW-1:2]));
    chk(tag, "R4 ir_out",   32'(ir_out),   32'(m_ir));
    chk(tag, "R5 ir_pc",    32'(ir_pc),    32'(m_irpc));
    chk(tag, "R10 ir_valid", 32'(ir_valid), 32'(m_valid));
  endtask

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) step(1, 0, 0, '0, "R1");
    for (int i = 0; i < 10; i++) step(0, 0, 0, '0, "R2");
    step(0, 0, 1, 16'h0102, "R6");
    step(0, 0, 0, '0, "R7");
    step(0, 0, 1, 16'h0207, "R6");
    for (int i = 0; i < 4; i++) step(0, 0, 0, '0, "R4");
    for (int i = 0; i < 3; i++) step(0, 1, 0, '0, "R8");
    step(0, 0, 0, '0, "R8");
    step(0, 1, 1, 16'h0400, "R9");
    step(0, 1, 0, '0, "R8");
    step(0, 0, 0, '0, "R9");
    step(0, 0, 1, 16'h0800, "R7");
    step(0, 0, 1, 16'h0A02, "R7");
    step(0, 0, 0, '0, "R10");
    step(0, 0, 1, 16'hFFFC, "R6");
    for (int i = 0; i < 4; i++) step(0, 0, 0, '0, "R11");
    for (int i = 0; i < 8; i++) step(0, (i % 2) == 0, 0, '0, "R8");
    step(1, 0, 0, '0, "R1");
    step(1, 1, 1, 16'h1234, "R1");
    for (int i = 0; i < 3; i++) step(0, 0, 0, '0, "R2");
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule